// File: doc/BRIEF.md
# Instruction Address Match Patcher

This block sits in the instruction fetch path and lets software redirect execution at up to two chosen code addresses without altering program memory. The address of the instruction about to be decoded is captured from the internal bus into a holding register whenever a valid strobe accompanies it. The held value is compared without pause against two programmable 24-bit trap addresses. Each comparator can be enabled or disabled on its own.

When an enabled comparator matches, the opcode travelling from fetch to decode is replaced by a fixed software-interrupt opcode. The core then vectors to a handler, which can run corrected code in place of the original instruction. With no enabled match, the fetched opcode passes through unchanged in the same cycle. A two-bit status output shows which comparators fired.

Software configures the block through a small register port with a select, a write strobe and a combinational read-back. Reset clears both trap addresses and both enables, so no substitution can happen until software sets the block up.

Top module: `addr_patch_top`

## Requirements
- R1: While reset is high, and after it is released, both enables, both trap addresses and the address holder are zero, all register reads return 0 and `hit` is 2'b00.
- R2: Writing select 1 loads trap address 0 and writing select 2 loads trap address 1, each with all 24 bits of `reg_wdata`. Reads of the same select return the stored value in the same cycle.
- R3: Select 0 is the control register. Bit 0 enables comparator 0 and bit 1 enables comparator 1. Bits 23:2 are reserved: they always read back as 0, whatever value is written.
- R4: The address holder loads `bus_addr` on a rising clock edge only when `bus_addr_vld` is 1. Otherwise it keeps its value.
- R5: `hit[i]` is 1 exactly when enable i is set and the held address equals trap address i. This is combinational, from the registered state.
- R6: A comparator whose enable bit is clear never sets its `hit` bit and never alters `opc_out`, even when its address matches.
- R7: When any `hit` bit is 1, `opc_out` equals the parameter `TRAP_OPC` (default 8'hE9).
- R8: When both comparators match the same address, `hit` is 2'b11 and `opc_out` carries one `TRAP_OPC` value.
- R9: When `hit` is 2'b00, `opc_out` equals `opc_in` in the same cycle.
- R10: Select 3 is unused: writes to it change no register and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 trap address 0, 2 trap address 1, 3 unused |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, combinational from `reg_sel` |
| bus_addr | input | 24 | Next-instruction address from the internal bus |
| bus_addr_vld | input | 1 | Load strobe for the address holder |
| opc_in | input | 8 | Opcode from fetch |
| opc_out | output | 8 | Opcode to decode, replaced on an enabled match |
| hit | output | 2 | Per-comparator match status |

## Verification
The bench goes after four corner cases:
- An address that matches a comparator whose enable is clear. A design that ignored the enable would insert the trap there.
- Both trap addresses set to the same value and both enabled. A wrong design would report only one comparator.
- A new bus address presented with the strobe low. A holder without a load gate would pick it up and fire or miss a trap wrongly.
- A control write with junk in the reserved bits, and a write to the unused select. A design that stored the reserved bits would read them back as nonzero, and one that decoded the unused select would corrupt a trap address.

// File: rtl/addr_patch_pkg.sv
package addr_patch_pkg;
    localparam int ADDR_W  = 24;
    localparam int OPC_W   = 8;
    localparam int NUM_CMP = 2;
    localparam int SEL_W   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADR0 = 2'd1,
        SEL_ADR1 = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_CMP-1:0]      en;
        addr_t [NUM_CMP-1:0]     adr;
    } patch_cfg_t;

    // Select code that addresses trap register idx
    function automatic reg_sel_e adr_sel(input int idx);
        return reg_sel_e'(idx + 1);
    endfunction

    // Control register image with reserved bits forced low
    function automatic addr_t ctrl_image(input logic [NUM_CMP-1:0] en);
        addr_t v;
        v = '0;
        v[NUM_CMP-1:0] = en;
        return v;
    endfunction
endpackage

// File: rtl/addr_patch_regs.sv
module addr_patch_regs
    import addr_patch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  addr_t            wdata,
    output addr_t            rdata,
    output patch_cfg_t       cfg
);
    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            if (sel_e == SEL_CTRL)
                cfg.en <= wdata[NUM_CMP-1:0];
            for (int i = 0; i < NUM_CMP; i++)
                if (sel_e == adr_sel(i))
                    cfg.adr[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_e == SEL_CTRL)
            rdata = ctrl_image(cfg.en);
        for (int i = 0; i < NUM_CMP; i++)
            if (sel_e == adr_sel(i))
                rdata = cfg.adr[i];
    end

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_e == SEL_CTRL) |-> (rdata[ADDR_W-1:NUM_CMP] == '0));

    // R10
    none_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_e == SEL_NONE) |-> (rdata == '0));

    // R10
    none_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && $past(sel_e) == SEL_NONE && !$past(rst)) |-> $stable(cfg));
endmodule

// File: rtl/addr_patch_latch.sv
module addr_patch_latch
    import addr_patch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  addr_t addr_in,
    output addr_t addr_q
);
    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (vld)
            addr_q <= addr_in;
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(vld) && !$past(rst)) |-> $stable(addr_q));
endmodule

// File: rtl/addr_patch_cmp.sv
module addr_patch_cmp
    import addr_patch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t cur_addr,
    input  addr_t trap_addr,
    input  logic  en,
    output logic  hit
);
    logic eq;
    assign eq  = (cur_addr == trap_addr);
    assign hit = en & eq;

    // R6
    hit_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> en);

    // R5
    hit_needs_eq_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (cur_addr == trap_addr));
endmodule

// File: rtl/addr_patch_top.sv
module addr_patch_top
    import addr_patch_pkg::*;
#(
    parameter logic [7:0] TRAP_OPC = 8'hE9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [23:0] reg_wdata,
    output logic [23:0] reg_rdata,
    input  logic [23:0] bus_addr,
    input  logic        bus_addr_vld,
    input  logic [7:0]  opc_in,
    output logic [7:0]  opc_out,
    output logic [1:0]  hit
);
    patch_cfg_t cfg;
    addr_t      cur_addr;
    logic [NUM_CMP-1:0] hit_vec;

    addr_patch_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    addr_patch_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .vld     (bus_addr_vld),
        .addr_in (bus_addr),
        .addr_q  (cur_addr)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        addr_patch_cmp u_cmp (
            .clk       (clk),
            .rst       (rst),
            .cur_addr  (cur_addr),
            .trap_addr (cfg.adr[g]),
            .en        (cfg.en[g]),
            .hit       (hit_vec[g])
        );
    end

    assign hit     = hit_vec;
    assign opc_out = (|hit_vec) ? opc_t'(TRAP_OPC) : opc_in;

    // R7
    trap_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |-> (opc_out == TRAP_OPC));

    // R9
    pass_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == 2'b00) |-> (opc_out == opc_in));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (hit == 2'b00));
endmodule

// File: tb/addr_patch_top_bench.sv
module addr_patch_top_bench;
    localparam logic [7:0] TRAP = 8'hE9;

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_we = 0;
    logic [1:0]  reg_sel = 0;
    logic [23:0] reg_wdata = 0;
    logic [23:0] reg_rdata;
    logic [23:0] bus_addr = 0;
    logic        bus_addr_vld = 0;
    logic [7:0]  opc_in = 0;
    logic [7:0]  opc_out;
    logic [1:0]  hit;

    int checks = 0;
    int errors = 0;

    logic [1:0]  m_en;
    logic [23:0] m_adr [2];
    logic [23:0] m_lat;

    addr_patch_top #(.TRAP_OPC(TRAP)) u_addr_patch_top (.*);

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [1:0] exp_hit();
        logic [1:0] h;
        for (int i = 0; i < 2; i++) h[i] = m_en[i] && (m_lat == m_adr[i]);
        return h;
    endfunction

    function automatic logic [7:0] exp_opc(input logic [7:0] o);
        return (exp_hit() != 0) ? TRAP : o;
    endfunction

    function automatic logic [23:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: return {22'd0, m_en};
            2'd1: return m_adr[0];
            2'd2: return m_adr[1];
            default: return 24'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [23:0] d);
        reg_we = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (s == 2'd0) m_en = d[1:0];
        else if (s != 2'd3) m_adr[s-1] = d;
    endtask

    task automatic rd(input logic [1:0] s, input string req);
        reg_sel = s; #1;
        chk(reg_rdata == exp_read(s), req, reg_rdata, exp_read(s));
    endtask

    task automatic load(input logic [23:0] a, input logic v);
        bus_addr = a; bus_addr_vld = v;
        @(negedge clk);
        bus_addr_vld = 0;
        if (v) m_lat = a;
    endtask

    // R5 R6 R7 R8 R9: observe the fetch path for one opcode
    task automatic obs(input string req);
        opc_in = 8'($urandom);
        #1;
        chk(hit == exp_hit(), req, {22'd0, hit}, {22'd0, exp_hit()});
        chk(opc_out == exp_opc(opc_in), req, {16'd0, opc_out}, {16'd0, exp_opc(opc_in)});
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_en = 0; m_adr[0] = 0; m_adr[1] = 0; m_lat = 0;
        // Load junk while reset is held
        reg_we = 1; reg_sel = 2'd0; reg_wdata = 24'hFFFFFF;
        bus_addr = 24'h123456; bus_addr_vld = 1;
        repeat (3) @(negedge clk);
        reg_we = 0; bus_addr_vld = 0;
        rst = 0;
        @(negedge clk);
        // R1
        for (int s = 0; s < 4; s++) rd(2'(s), "R1");
        obs("R1");

        // R2 readback of both trap addresses
        wr(2'd1, 24'hABCDEF); rd(2'd1, "R2");
        wr(2'd2, 24'h00F00D); rd(2'd2, "R2");

        // R3 reserved bits dropped
        wr(2'd0, 24'hFFFFFC); rd(2'd0, "R3");

        // R6 match with enables clear
        load(24'hABCDEF, 1); obs("R6");

        // R5 R7 enable comparator 0
        wr(2'd0, 24'h000001); obs("R7");

        // R4 new address without strobe: still held
        load(24'h00F00D, 0); obs("R4");
        // R9 miss with strobe to another address
        load(24'h777777, 1); obs("R9");

        // R8 both match same address
        wr(2'd1, 24'h777777); wr(2'd2, 24'h777777); wr(2'd0, 24'h000003);
        obs("R8");
        // R6 disable comparator 1 only
        wr(2'd0, 24'h000001); obs("R6");

        // R10 unused select
        wr(2'd3, 24'h5A5A5A);
        for (int s = 0; s < 4; s++) rd(2'(s), "R10");
        obs("R10");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int act;
            act = int'($urandom_range(0, 5));
            case (act)
                0: wr(2'd0, 24'($urandom));
                1: wr(2'($urandom_range(1, 2)), ($urandom_range(0, 1) != 0) ? m_lat : 24'($urandom));
                2: load(m_adr[$urandom_range(0, 1)], 1'($urandom));
                3: load(24'($urandom), 1'($urandom));
                4: wr(2'd3, 24'($urandom));
                default: load(m_adr[0], 1);
            endcase
            rd(2'($urandom), "R2");
            obs("R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule